// File: doc/BRIEF.md
# Basic-Mode DMA Channel Engine

This block is one DMA channel that copies a programmed number of items from a source region to a destination region. Software loads three values with a single load strobe: the inclusive end address of the source, the inclusive end address of the destination, and a 32-bit control word. The control word selects the address step and item width for each side, the item count, the size of an arbitration group and the run mode. Each address is derived from its end pointer and the count that remains. A side whose step is "fixed" keeps its address on the end pointer, which suits a peripheral data register.

A peripheral asks for service with a single-item strobe or a burst strobe. When the channel accepts a request it raises an ownership request towards a shared arbiter. After the grant it keeps ownership for a whole group of items, then releases it and waits for the next request. Each item is moved as a read on the memory port followed by a write one cycle later. When the count runs out, the channel clears its mode field, leaves the count field at zero, and pulses a done flag for one cycle.

Top module: `dma_basic_chan`

## Requirements
- R1: A stepping side uses the address `end - remaining*step` for each item, where `remaining` is the number of items still to go after the current one. The last item therefore lands exactly on the inclusive end pointer.
- R2: The destination step sits in control bits 31:30 and the source step in bits 27:26. Codes 0, 1 and 2 step by 1, 2 and 4 bytes. Code 3 holds that address on its end pointer for every item.
- R3: The destination item width sits in bits 29:28 and the source item width in bits 25:24. Codes 0, 1 and 2 select 1, 2 and 4 bytes, and `memSize` carries that code. The written data is the read data with every byte above the item width forced to zero.
- R4: Bits 13:4 hold the item count minus one. A loaded value of N-1 moves exactly N items.
- R5: Bits 2:0 hold the mode. Code 1 runs the channel. Code 0 leaves it stopped with no ownership request, no memory access and no error, even while requests are present.
- R6: `cfgError` is high while the mode field is non-zero and the configuration is illegal. The configuration is illegal when the mode is not 1, when a width code is 3, when the two widths differ, or when a stepping side has a step code below its width code. The channel then makes no ownership request and no memory access.
- R7: An accepted burst request moves min(2^A, items left) items under one grant, where A is bits 17:14. `arbReq` stays high from the request until the last write of the group, then drops.
- R8: An accepted single request moves exactly one item under its own grant.
- R9: While `useBurstOnly` is high, single requests are ignored. No group starts unless `reqBurst` was high.
- R10: When `reqBurst` and `reqSingle` are both high in the cycle a request is taken, the burst wins and a full group is moved.
- R11: `done` is high for exactly the one cycle after the final write. In that cycle `ctlStatus` shows mode 0 and count 0, with all other fields as loaded. Requests after that start nothing.
- R12: Every write follows its read by one cycle. The write data is the value `memRdData` returned for that read.
- R13: During reset every output is low and `ctlStatus` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgLoad | input | 1 | Loads pointers and control word; aborts any running transfer |
| srcEndPtr | input | ADDR_W | Inclusive last source address |
| dstEndPtr | input | ADDR_W | Inclusive last destination address |
| ctlWord | input | 32 | Control word |
| useBurstOnly | input | 1 | Ignore single requests |
| reqSingle | input | 1 | Single-item request from the peripheral |
| reqBurst | input | 1 | Burst request from the peripheral |
| arbReq | output | 1 | Ownership request, held for the whole group |
| arbGrant | input | 1 | Grant from the shared arbiter |
| memRdEn | output | 1 | Read strobe |
| memRdAddr | output | ADDR_W | Read byte address |
| memRdData | input | 32 | Read data, valid the cycle after `memRdEn` |
| memWrEn | output | 1 | Write strobe |
| memWrAddr | output | ADDR_W | Write byte address |
| memWrData | output | 32 | Write data, right-aligned |
| memSize | output | 2 | Item width code for both accesses |
| done | output | 1 | One-cycle completion pulse |
| cfgError | output | 1 | Illegal configuration flag |
| ctlStatus | output | 32 | Control word as written back (live count and mode) |

## Verification
Two pairs of events can fall in the same cycle. Both request strobes can be high together when the channel samples them. A new request can also be pending in the very cycle that the final write completes and `done` is about to fire. The first case is provoked by driving both strobes permanently high and by a FIFO-shaped peripheral whose free space often raises both. It is judged by counting the writes between each rise and fall of `arbReq` against the burst group size. The second case is provoked by holding both strobes high after completion. It is judged by requiring a single-cycle `done`, a zeroed count and mode in `ctlStatus`, and no further `arbReq` or memory access.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  localparam int CTL_W  = 32;
  localparam int CNT_W  = 10;
  localparam int ARB_W  = 4;
  localparam int DATA_W = 32;
  localparam int HI_W   = CTL_W - 14;

  localparam logic [2:0] MODE_STOP  = 3'd0;
  localparam logic [2:0] MODE_BASIC = 3'd1;
  localparam logic [1:0] INC_FIXED  = 2'd3;
  localparam logic [1:0] SIZE_BAD   = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ARB,
    ST_RD,
    ST_WR
  } chanState_e;

  typedef struct packed {
    logic [1:0]       dstInc;
    logic [1:0]       dstSize;
    logic [1:0]       srcInc;
    logic [1:0]       srcSize;
    logic [ARB_W-1:0] arbExp;
  } ctlFields_t;

  typedef struct packed {
    logic load;
    logic itemDone;
  } pathStrobes_t;

  function automatic logic sideOk(input logic [1:0] inc, input logic [1:0] sz);
    return (inc == INC_FIXED) || (inc >= sz);
  endfunction

endpackage

// File: rtl/dma_chan_path.sv
module dma_chan_path
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  pathStrobes_t       strb,
  input  logic [ADDR_W-1:0]  srcEndIn,
  input  logic [ADDR_W-1:0]  dstEndIn,
  input  logic [CTL_W-1:0]   ctlIn,
  input  logic [DATA_W-1:0]  rdData,
  output ctlFields_t         fields,
  output logic               runnable,
  output logic               cfgError,
  output logic [CNT_W-1:0]   cntRem,
  output logic [ADDR_W-1:0]  rdAddr,
  output logic [ADDR_W-1:0]  wrAddr,
  output logic [DATA_W-1:0]  wrData,
  output logic [1:0]         itemSize,
  output logic [CTL_W-1:0]   ctlOut
);

  localparam int BYTES = DATA_W / 8;

  logic [ADDR_W-1:0] srcEndQ, dstEndQ;
  logic [HI_W-1:0]   ctlHiQ;
  logic              ctlB3Q;
  logic [CNT_W-1:0]  cntRemQ;
  logic [2:0]        modeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcEndQ <= '0;
      dstEndQ <= '0;
      ctlHiQ  <= '0;
      ctlB3Q  <= 1'b0;
      cntRemQ <= '0;
      modeQ   <= MODE_STOP;
    end else if (strb.load) begin
      srcEndQ <= srcEndIn;
      dstEndQ <= dstEndIn;
      ctlHiQ  <= ctlIn[CTL_W-1:14];
      ctlB3Q  <= ctlIn[3];
      cntRemQ <= ctlIn[13:4];
      modeQ   <= ctlIn[2:0];
    end else if (strb.itemDone) begin
      if (cntRemQ == '0) modeQ <= MODE_STOP;
      else               cntRemQ <= cntRemQ - 1'b1;
    end
  end

  always_comb begin
    fields.dstInc  = ctlHiQ[17:16];
    fields.dstSize = ctlHiQ[15:14];
    fields.srcInc  = ctlHiQ[13:12];
    fields.srcSize = ctlHiQ[11:10];
    fields.arbExp  = ctlHiQ[ARB_W-1:0];
  end

  logic legalCfg;
  assign legalCfg = (modeQ == MODE_BASIC)
                 && (fields.srcSize == fields.dstSize)
                 && (fields.srcSize != SIZE_BAD)
                 && sideOk(fields.srcInc, fields.srcSize)
                 && sideOk(fields.dstInc, fields.dstSize);

  assign runnable = legalCfg;
  assign cfgError = (modeQ != MODE_STOP) && !legalCfg;
  assign cntRem   = cntRemQ;
  assign itemSize = fields.srcSize;
  assign ctlOut   = {ctlHiQ, cntRemQ, ctlB3Q, modeQ};

  for (genvar s = 0; s < 2; s++) begin : g_side
    logic [ADDR_W-1:0] endP;
    logic [1:0]        incC;
    logic [ADDR_W-1:0] addr;
    assign endP = (s == 0) ? srcEndQ : dstEndQ;
    assign incC = (s == 0) ? fields.srcInc : fields.dstInc;
    assign addr = (incC == INC_FIXED) ? endP : endP - (ADDR_W'(cntRemQ) << incC);
  end
  assign rdAddr = g_side[0].addr;
  assign wrAddr = g_side[1].addr;

  for (genvar b = 0; b < BYTES; b++) begin : g_mask
    assign wrData[8*b +: 8] = (b < (1 << fields.srcSize)) ? rdData[8*b +: 8] : 8'h00;
  end

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgLoad,
  input  logic             runnable,
  input  logic [CNT_W-1:0] cntRem,
  input  logic [ARB_W-1:0] arbExp,
  input  logic             reqSingle,
  input  logic             reqBurst,
  input  logic             useBurstOnly,
  input  logic             arbGrant,
  output pathStrobes_t     strb,
  output logic             arbReq,
  output logic             memRdEn,
  output logic             memWrEn,
  output logic             done
);

  localparam int GRP_W = (1 << ARB_W) + 1;

  chanState_e        stateQ;
  logic [GRP_W-1:0]  groupLeftQ;
  logic              doneQ;

  logic             singlePick, lastItem;
  logic [GRP_W-1:0] fullGroup, itemsLeft, burstLen;

  assign singlePick = reqSingle && !useBurstOnly;
  assign lastItem   = (cntRem == '0);
  assign fullGroup  = GRP_W'(1) << arbExp;
  assign itemsLeft  = GRP_W'(cntRem) + 1'b1;
  assign burstLen   = (fullGroup < itemsLeft) ? fullGroup : itemsLeft;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ     <= ST_IDLE;
      groupLeftQ <= '0;
      doneQ      <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (cfgLoad) begin
        stateQ     <= ST_IDLE;
        groupLeftQ <= '0;
      end else begin
        case (stateQ)
          ST_IDLE: if (runnable) stateQ <= ST_WAIT;
          ST_WAIT: begin
            if (!runnable) begin
              stateQ <= ST_IDLE;
            end else if (reqBurst) begin
              stateQ     <= ST_ARB;
              groupLeftQ <= burstLen;
            end else if (singlePick) begin
              stateQ     <= ST_ARB;
              groupLeftQ <= GRP_W'(1);
            end
          end
          ST_ARB:  if (arbGrant) stateQ <= ST_RD;
          ST_RD:   stateQ <= ST_WR;
          ST_WR: begin
            groupLeftQ <= groupLeftQ - 1'b1;
            if (lastItem) begin
              stateQ <= ST_IDLE;
              doneQ  <= 1'b1;
            end else if (groupLeftQ == GRP_W'(1)) begin
              stateQ <= ST_WAIT;
            end else begin
              stateQ <= ST_RD;
            end
          end
          default: stateQ <= ST_IDLE;
        endcase
      end
    end
  end

  assign strb.load     = cfgLoad;
  assign strb.itemDone = (stateQ == ST_WR);
  assign memRdEn       = (stateQ == ST_RD);
  assign memWrEn       = (stateQ == ST_WR);
  assign arbReq        = (stateQ == ST_ARB) || (stateQ == ST_RD) || (stateQ == ST_WR);
  assign done          = doneQ;

  assert_rd_then_wr_R12: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn && !cfgLoad) |=> memWrEn);

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_rd_owned_R7: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn || memWrEn) |-> arbReq);

  assert_burst_only_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_ARB && $past(stateQ) == ST_WAIT && $past(useBurstOnly)) |-> $past(reqBurst));

endmodule

// File: rtl/dma_basic_chan.sv
module dma_basic_chan
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgLoad,
  input  logic [ADDR_W-1:0] srcEndPtr,
  input  logic [ADDR_W-1:0] dstEndPtr,
  input  logic [31:0]       ctlWord,
  input  logic              useBurstOnly,
  input  logic              reqSingle,
  input  logic              reqBurst,
  output logic              arbReq,
  input  logic              arbGrant,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [31:0]       memRdData,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [31:0]       memWrData,
  output logic [1:0]        memSize,
  output logic              done,
  output logic              cfgError,
  output logic [31:0]       ctlStatus
);

  pathStrobes_t     strb;
  ctlFields_t       fields;
  logic             runnable;
  logic [CNT_W-1:0] cntRem;

  dma_chan_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cfgLoad      (cfgLoad),
    .runnable     (runnable),
    .cntRem       (cntRem),
    .arbExp       (fields.arbExp),
    .reqSingle    (reqSingle),
    .reqBurst     (reqBurst),
    .useBurstOnly (useBurstOnly),
    .arbGrant     (arbGrant),
    .strb         (strb),
    .arbReq       (arbReq),
    .memRdEn      (memRdEn),
    .memWrEn      (memWrEn),
    .done         (done)
  );

  dma_chan_path #(.ADDR_W(ADDR_W)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .srcEndIn (srcEndPtr),
    .dstEndIn (dstEndPtr),
    .ctlIn    (ctlWord),
    .rdData   (memRdData),
    .fields   (fields),
    .runnable (runnable),
    .cfgError (cfgError),
    .cntRem   (cntRem),
    .rdAddr   (memRdAddr),
    .wrAddr   (memWrAddr),
    .wrData   (memWrData),
    .itemSize (memSize),
    .ctlOut   (ctlStatus)
  );

  assert_err_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |-> (!memRdEn && !memWrEn && !arbReq));

  assert_done_status_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (ctlStatus[2:0] == 3'd0 && ctlStatus[13:4] == 10'd0));

endmodule

// File: tb/dma_basic_chan_bench.sv
module dma_basic_chan_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          cfgLoad = 1'b0;
  logic [AW-1:0] srcEndPtr = '0, dstEndPtr = '0;
  logic [31:0]   ctlWord = '0;
  logic          useBurstOnly = 1'b0, reqSingle = 1'b0, reqBurst = 1'b0;
  logic          arbReq, arbGrant = 1'b0;
  logic          memRdEn, memWrEn, done, cfgError;
  logic [AW-1:0] memRdAddr, memWrAddr;
  logic [31:0]   memRdData = '0, memWrData, ctlStatus;
  logic [1:0]    memSize;

  dma_basic_chan #(.ADDR_W(AW)) u_dma_basic_chan (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .srcEndPtr(srcEndPtr), .dstEndPtr(dstEndPtr),
    .ctlWord(ctlWord), .useBurstOnly(useBurstOnly), .reqSingle(reqSingle), .reqBurst(reqBurst),
    .arbReq(arbReq), .arbGrant(arbGrant), .memRdEn(memRdEn), .memRdAddr(memRdAddr),
    .memRdData(memRdData), .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .memSize(memSize), .done(done), .cfgError(cfgError), .ctlStatus(ctlStatus)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // transfer expectations
  int expN = 0, srcInc = 0, dstInc = 0, expSize = 0, expArb = 0;
  logic [AW-1:0] srcEnd = '0, dstEnd = '0;
  int rdIdx = 0, wrIdx = 0, grpCount = 0, grpExp = 0;
  bit monOn = 0, prevRd = 0, prevArb = 0, prevBurstDrv = 0, prevSingleDrv = 0;
  bit grpBurst = 0, grpBoth = 0, grantTick = 0;
  int fifoFree = 8, drainCnt = 0, reqPat = 3;

  function automatic logic [AW-1:0] itemAddr(input logic [AW-1:0] e, input int inc, input int k);
    if (inc == 3) return e;
    return e - AW'((expN - 1 - k) << inc);
  endfunction

  function automatic logic [7:0] srcByte(input logic [AW-1:0] a);
    return 8'((32'(a) * 5) ^ (32'(a) >> 7) ^ 32'h3C);
  endfunction

  function automatic logic [31:0] wordAt(input logic [AW-1:0] a);
    return {srcByte(a + 16'd3), srcByte(a + 16'd2), srcByte(a + 16'd1), srcByte(a)};
  endfunction

  function automatic logic [31:0] sizeMask(input int sz);
    return (sz == 0) ? 32'h0000_00FF : (sz == 1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] mk(input int si, input int ssz, input int di, input int dsz,
                                     input int arb, input int cnt, input int mode);
    return {2'(di), 2'(dsz), 2'(si), 2'(ssz), 6'd0, 4'(arb), 10'(cnt), 1'b0, 3'(mode)};
  endfunction

  // source memory: one-cycle read latency
  always @(posedge clk) if (memRdEn) memRdData <= wordAt(memRdAddr);

  // monitor, FIFO peripheral model and arbiter model
  always @(negedge clk) begin
    int left;
    logic [31:0] expD;
    if (monOn) begin
      if (arbReq && !prevArb) begin
        left = expN - wrIdx;
        grpBurst = prevBurstDrv;
        grpBoth = prevBurstDrv && prevSingleDrv;
        grpExp = prevBurstDrv ? (((1 << expArb) < left) ? (1 << expArb) : left) : 1;
        grpCount = 0;
        if (useBurstOnly) chk(prevBurstDrv, "R9", 32'(prevBurstDrv), 32'd1);
      end
      if (memRdEn) begin
        chk(memRdAddr == itemAddr(srcEnd, srcInc, rdIdx), (srcInc == 3) ? "R2" : "R1",
            32'(memRdAddr), 32'(itemAddr(srcEnd, srcInc, rdIdx)));
        chk(memSize == 2'(expSize), "R3", 32'(memSize), 32'(expSize));
        rdIdx++;
      end
      if (memWrEn) begin
        chk(prevRd, "R12", 32'(prevRd), 32'd1);
        chk(memWrAddr == itemAddr(dstEnd, dstInc, wrIdx), (dstInc == 3) ? "R2" : "R1",
            32'(memWrAddr), 32'(itemAddr(dstEnd, dstInc, wrIdx)));
        expD = wordAt(itemAddr(srcEnd, srcInc, wrIdx)) & sizeMask(expSize);
        chk(memWrData == expD, "R12/R3", memWrData, expD);
        wrIdx++;
        grpCount++;
        if (fifoFree > 0) fifoFree--;
      end
      if (!arbReq && prevArb)
        chk(grpCount == grpExp, grpBurst ? (grpBoth ? "R10" : "R7") : "R8",
            32'(grpCount), 32'(grpExp));
    end
    prevRd = memRdEn;
    prevArb = arbReq;
    grantTick = ~grantTick;
    arbGrant = arbReq && grantTick;
    drainCnt++;
    if (drainCnt == 3) begin
      drainCnt = 0;
      if (fifoFree < 8) fifoFree++;
    end
    case (reqPat)
      0: begin reqBurst = (fifoFree >= 4); reqSingle = (fifoFree >= 1); end
      1: begin reqBurst = 1'b1; reqSingle = 1'b1; end
      2: begin reqBurst = 1'b0; reqSingle = 1'b1; end
      default: begin reqBurst = 1'b0; reqSingle = 1'b0; end
    endcase
    prevBurstDrv = reqBurst;
    prevSingleDrv = reqSingle;
  end

  task automatic loadCfg(input logic [31:0] w, input logic [AW-1:0] s, input logic [AW-1:0] d);
    @(posedge clk); #1;
    ctlWord = w; srcEndPtr = s; dstEndPtr = d; cfgLoad = 1'b1;
    @(posedge clk); #1;
    cfgLoad = 1'b0;
  endtask

  task automatic runXfer(input int si, input int di, input int sz, input int arb, input int n,
                         input bit ub, input int pat, input bit preSingle);
    logic [31:0] w, expStat;
    int t;
    bit seen;
    w = mk(si, sz, di, sz, arb, n - 1, 1);
    expStat = w & ~32'h0000_3FF7;
    expN = n; srcInc = si; dstInc = di; expSize = sz; expArb = arb;
    srcEnd = 16'h3F40; dstEnd = 16'h7F80;
    rdIdx = 0; wrIdx = 0; fifoFree = 8; reqPat = 3;
    @(posedge clk); #1;
    useBurstOnly = ub;
    monOn = 1;
    loadCfg(w, srcEnd, dstEnd);
    if (preSingle) begin
      reqPat = 2;
      repeat (12) begin
        @(negedge clk);
        chk(!arbReq && !memRdEn, "R9", {arbReq, memRdEn}, 0);
      end
      chk(ctlStatus == w, "R9", ctlStatus, w);
    end
    reqPat = pat;
    t = 0; seen = 0;
    while (t < 4000 && !seen) begin
      @(negedge clk);
      t++;
      if (done) seen = 1;
    end
    chk(seen, "R11", 32'(seen), 1);
    chk(ctlStatus == expStat, "R11", ctlStatus, expStat);
    chk(wrIdx == n && rdIdx == n, "R4", 32'(wrIdx), 32'(n));
    reqPat = 1;
    @(negedge clk);
    chk(!done, "R11", 32'(done), 0);
    repeat (8) begin
      @(negedge clk);
      chk(!arbReq && !memRdEn, "R11", {arbReq, memRdEn}, 0);
    end
    reqPat = 3;
    monOn = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] bad [4];
    logic [31:0] w0;
    int run;
    repeat (3) @(negedge clk);
    chk(!arbReq && !memRdEn && !memWrEn && !done && !cfgError, "R13",
        {arbReq, memRdEn, memWrEn, done, cfgError}, 0);
    chk(ctlStatus == 32'd0, "R13", ctlStatus, 0);
    @(posedge clk); #1;
    rstN = 1'b1;

    // stopped mode
    w0 = mk(0, 0, 3, 0, 2, 7, 0);
    loadCfg(w0, 16'h1000, 16'h2000);
    reqPat = 1;
    repeat (10) begin
      @(negedge clk);
      chk(!arbReq && !memRdEn && !cfgError, "R5", {arbReq, memRdEn, cfgError}, 0);
    end
    chk(ctlStatus == w0, "R5", ctlStatus, w0);
    reqPat = 3;

    // illegal configurations
    bad[0] = mk(0, 3, 0, 3, 2, 7, 1);
    bad[1] = mk(0, 0, 0, 1, 2, 7, 1);
    bad[2] = mk(0, 2, 3, 2, 2, 7, 1);
    bad[3] = mk(0, 0, 0, 0, 2, 7, 5);
    for (int i = 0; i < 4; i++) begin
      loadCfg(bad[i], 16'h1000, 16'h2000);
      reqPat = 1;
      repeat (8) begin
        @(negedge clk);
        chk(cfgError && !arbReq && !memRdEn, "R6", {cfgError, arbReq, memRdEn}, 3'b100);
      end
      chk(ctlStatus == bad[i], "R6", ctlStatus, bad[i]);
      reqPat = 3;
    end

    // sweep of every legal step/width combination
    run = 0;
    for (int sz = 0; sz < 3; sz++)
      for (int si = 0; si < 4; si++)
        for (int di = 0; di < 4; di++)
          if ((si == 3 || si >= sz) && (di == 3 || di >= sz)) begin
            runXfer(si, di, sz, run % 4, 5 + run % 5, (run % 3) == 2, 0, 0);
            run++;
          end

    runXfer(0, 3, 0, 2, 10, 0, 1, 0);   // both strobes high: R10
    runXfer(2, 2, 2, 0, 6, 0, 2, 0);    // single only: R8
    runXfer(0, 3, 0, 2, 9, 1, 0, 1);    // singles ignored first: R9
    runXfer(1, 1, 1, 15, 20, 0, 1, 0);  // group larger than count: R7

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule